// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of an 8-bit successive-approximation converter with four analog inputs. Software uses a small byte-wide register port. One control register holds the channel field, the start bit and the end-of-conversion flag. A separate read-only register holds the result. While a conversion runs, the block drives a trial code to an external resistor-string DAC and a channel number to the analog multiplexer. It reads one comparator bit for each decided bit.

A conversion begins when software writes a 1 to the start bit while the block is idle. The approximation register is loaded with the mid-scale code 80h, and the channel is captured from the written value. The block then settles one bit per step, from the most significant bit to the least. Each step lasts `STEP_CYCLES` clocks so the DAC output can settle. After the last step the result register is overwritten, the flag is raised, the start bit drops and the block goes back to idle.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control register and the result register both read 00h, `dac_code` is 00h and `mux_sel` is 0.
- R2: A write to address F7h with bit 0 set, made while idle, starts a conversion. From the next cycle `dac_code` is 80h, and the control register reads bit 0 = 1 and bit 3 = 0.
- R3: `cmp_in` = 1 means the input is at or above `dac_code`. At each step the bit under test is cleared when `cmp_in` = 0, and the next lower bit is then set. The result at address F6h equals the integer input level, including 00h and FFh.
- R4: On completion the result register, bit 3 (set to 1) and bit 0 (cleared to 0) of the control register all change on the same clock edge. That edge falls 8×`STEP_CYCLES` cycles after the starting write edge.
- R5: `mux_sel` takes bits 5:4 of the value written when the conversion starts and holds it until the conversion ends, even if the control register is rewritten meanwhile.
- R6: Each completed conversion overwrites the result register, whether or not it was read.
- R7: Control bits 7, 2 and 1 always read 0. Software writes to bit 3 have no effect. Bits 6:4 read back as last written.
- R8: A write to the start bit during a conversion neither restarts nor stops it. Completion still occurs at the original time.
- R9: Each trial code is held on `dac_code` for exactly `STEP_CYCLES` cycles. The codes follow the binary search of R3.
- R10: Reads of any other address return 00h, and writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address (F7h control, F6h result) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial code |
| dac_code | output | 8 | Trial code to the resistor-string DAC |
| mux_sel | output | 2 | Analog multiplexer channel |

## Verification
The hardest situation to reach is a control-register write that lands in the middle of a running conversion. Such a write must change the readable channel field while the multiplexer and the completion time stay as they were. The stimulus starts a conversion on one channel and, a few cycles later, writes a different channel with the start bit set again. It then counts clocks from the starting edge. It checks that the start bit is still high one cycle before the expected edge and that the result comes from the first channel. The trial-code walk is also checked clock by clock against a binary search in the bench, for mid-scale, both full-scale ends and the code just below mid-scale.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_t;

  localparam int CTRL_START_POS = 0;
  localparam int CTRL_EOC_POS   = 3;
  localparam int CTRL_CH_LSB    = 4;
  localparam int CTRL_CH_W      = 3;
endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_adc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int ADDR_W    = 8,
  parameter int SEL_W     = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF7,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'hF6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DW-1:0]     result_in,
  output logic              start_req,
  output logic [SEL_W-1:0]  start_ch,
  output logic              start_bit,
  output logic              eoc_bit,
  output logic [DW-1:0]     result_q
);
  logic                 ctrl_hit;
  logic [CTRL_CH_W-1:0] ch_q, ch_d;
  logic                 ch_en;
  logic                 start_q, start_d;
  logic                 eoc_q, eoc_d;
  logic                 flag_en;
  logic [DW-1:0]        result_d;
  logic                 result_en;
  logic [7:0]           ctrl_view;
  logic                 unused_wbits;

  assign ctrl_hit  = bus_wr && (bus_addr == CTRL_ADDR);
  assign start_req = ctrl_hit && bus_wdata[CTRL_START_POS] && !busy;
  assign start_ch  = bus_wdata[CTRL_CH_LSB +: SEL_W];
  assign unused_wbits = ^{bus_wdata[DW-1:7], bus_wdata[2:1], bus_wdata[CTRL_EOC_POS]};

  // next-state
  always_comb begin
    ch_en     = ctrl_hit;
    ch_d      = bus_wdata[CTRL_CH_LSB +: CTRL_CH_W];
    flag_en   = start_req || done;
    start_d   = start_q;
    eoc_d     = eoc_q;
    if (done) begin
      start_d = 1'b0;
      eoc_d   = 1'b1;
    end else if (start_req) begin
      start_d = 1'b1;
      eoc_d   = 1'b0;
    end
    result_en = done;
    result_d  = result_in;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q     <= '0;
      start_q  <= 1'b0;
      eoc_q    <= 1'b0;
      result_q <= '0;
    end else begin
      if (ch_en)     ch_q     <= ch_d;
      if (flag_en) begin
        start_q <= start_d;
        eoc_q   <= eoc_d;
      end
      if (result_en) result_q <= result_d;
    end
  end

  // read mux
  always_comb begin
    ctrl_view = 8'h00;
    ctrl_view[CTRL_CH_LSB +: CTRL_CH_W] = ch_q;
    ctrl_view[CTRL_EOC_POS]             = eoc_q;
    ctrl_view[CTRL_START_POS]           = start_q;
    if (bus_addr == CTRL_ADDR)      bus_rdata = DW'(ctrl_view);
    else if (bus_addr == DATA_ADDR) bus_rdata = result_q;
    else                            bus_rdata = '0;
  end

  assign start_bit = start_q;
  assign eoc_bit   = eoc_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int STEP_CYCLES = 2,
  localparam int IW         = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  output logic          busy,
  output logic          strobe,
  output logic          done,
  output logic [IW-1:0] idx
);
  sar_state_t    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          state_en;

  assign busy = (state_q == ST_CONV);
  assign idx  = idx_q;
  assign done = strobe && (idx_q == '0);

  generate
    if (STEP_CYCLES == 1) begin : g_no_timer
      assign strobe = busy;
    end else begin : g_timer
      localparam int TW = $clog2(STEP_CYCLES);
      logic [TW-1:0] tmr_q, tmr_d;
      logic          tmr_en;
      assign strobe = busy && (tmr_q == TW'(STEP_CYCLES - 1));
      always_comb begin
        tmr_en = start_req || busy;
        if (start_req || strobe) tmr_d = '0;
        else                     tmr_d = tmr_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tmr_q <= '0;
        else if (tmr_en) tmr_q <= tmr_d;
      end
    end
  endgenerate

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    state_en = start_req || strobe;
    if (start_req) begin
      state_d = ST_CONV;
      idx_d   = IW'(DW - 1);
    end else if (strobe) begin
      if (idx_q == '0) state_d = ST_IDLE;
      else             idx_d   = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (state_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int DW    = 8,
  parameter int SEL_W = 2,
  localparam int IW   = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             strobe,
  input  logic [IW-1:0]    idx,
  input  logic             cmp_in,
  input  logic [SEL_W-1:0] ch_in,
  output logic [DW-1:0]    dac_code,
  output logic [SEL_W-1:0] mux_sel,
  output logic [DW-1:0]    resolved
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0]    sar_q, sar_d;
  logic             sar_en;
  logic [SEL_W-1:0] ch_q;

  always_comb begin
    resolved = sar_q;
    if (!cmp_in)     resolved[idx] = 1'b0;
    if (idx != '0)   resolved[idx - 1'b1] = 1'b1;
    sar_en = load || strobe;
    sar_d  = load ? MID : resolved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      ch_q  <= '0;
    end else begin
      if (sar_en) sar_q <= sar_d;
      if (load)   ch_q  <= ch_in;
    end
  end

  assign dac_code = sar_q;
  assign mux_sel  = ch_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int DW          = 8,
  parameter int ADDR_W      = 8,
  parameter int CH_COUNT    = 4,
  parameter int STEP_CYCLES = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF7,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'hF6,
  localparam int SEL_W = $clog2(CH_COUNT),
  localparam int IW    = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              cmp_in,
  output logic [DW-1:0]     dac_code,
  output logic [SEL_W-1:0]  mux_sel
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic                   busy, strobe, done, start_req;
  logic [IW-1:0]          idx;
  logic [SEL_W-1:0]       start_ch;
  logic                   start_bit, eoc_bit;
  logic [DW-1:0]          result_q, resolved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  sar_regs #(
    .DW(DW), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .result_in(resolved), .start_req(start_req), .start_ch(start_ch),
    .start_bit(start_bit), .eoc_bit(eoc_bit), .result_q(result_q)
  );

  sar_seq #(.DW(DW), .STEP_CYCLES(STEP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_req(start_req),
    .busy(busy), .strobe(strobe), .done(done), .idx(idx)
  );

  sar_core #(.DW(DW), .SEL_W(SEL_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .load(start_req), .strobe(strobe),
    .idx(idx), .cmp_in(cmp_in), .ch_in(start_ch),
    .dac_code(dac_code), .mux_sel(mux_sel), .resolved(resolved)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int DW    = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             start_req,
  input logic             done,
  input logic [DW-1:0]    dac_code,
  input logic [SEL_W-1:0] mux_sel,
  input logic             start_bit,
  input logic             eoc_bit,
  input logic [DW-1:0]    result
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  AST_MIDSCALE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (busy && dac_code == MID)); // R2

  AST_FLAGS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (start_bit && !eoc_bit)); // R4

  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (eoc_bit && !start_bit && !busy)); // R4

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel)); // R5

  AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable(result)); // R6

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_req); // R8
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DW(DW), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .start_req(start_req),
  .done(done), .dac_code(dac_code), .mux_sel(mux_sel),
  .start_bit(start_bit), .eoc_bit(eoc_bit), .result(result_q)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 2;
  localparam logic [7:0] CTRL = 8'hF7;
  localparam logic [7:0] DATA = 8'hF6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata, dac_code;
  logic       bus_wr, cmp_in;
  logic [1:0] mux_sel;
  logic [7:0] ain [4];

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] exp_q[$];
  logic [7:0] obs_val;
  event       ev_obs;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp_in = (ain[mux_sel] >= dac_code);

  sar_adc_ctrl #(.STEP_CYCLES(STEPS)) u_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .dac_code(dac_code), .mux_sel(mux_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // scoreboard monitor
  always @(ev_obs) begin
    logic [7:0] e;
    if (exp_q.size() == 0) chk(1'b0, "R3 queue", obs_val, 0);
    else begin
      e = exp_q.pop_front();
      chk(obs_val == e, "R3 result", obs_val, e);
    end
  end

  task automatic publish();
    logic [7:0] v;
    bus_read(DATA, v);
    obs_val = v;
    ->ev_obs;
    #1;
  endtask

  task automatic run_conv(input int ch, input bit trials);
    logic [7:0] v, code;
    int t0;
    exp_q.push_back(ain[ch]);
    bus_write(CTRL, 8'((ch << 4) | 1));
    t0 = cyc;
    bus_read(CTRL, v);
    chk(v == 8'((ch << 4) | 1), "R2 ctrl busy", v, (ch << 4) | 1);
    chk(dac_code == 8'h80, "R2 midscale", dac_code, 8'h80);
    chk(mux_sel == 2'(ch), "R5 mux", mux_sel, ch);
    if (trials) begin
      code = 8'h80;
      for (int k = 7; k >= 0; k--) begin
        for (int j = 0; j < STEPS; j++) begin
          chk(dac_code == code, "R9 trial", dac_code, code);
          @(negedge clk);
        end
        if (ain[ch] < code) code[k] = 1'b0;
        if (k > 0) code[k-1] = 1'b1;
      end
    end else begin
      while (cyc < t0 + 8*STEPS) @(negedge clk);
    end
    bus_read(CTRL, v);
    chk(v == 8'((ch << 4) | 8), "R4 done flags", v, (ch << 4) | 8);
    publish();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act=%0d exp=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int t0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    ain[0] = 8'h5A; ain[1] = 8'hFF; ain[2] = 8'h80; ain[3] = 8'h7F;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(CTRL, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    bus_read(DATA, v); chk(v == 8'h00, "R1 data", v, 0);
    chk(dac_code == 8'h00, "R1 dac", dac_code, 0);
    chk(mux_sel == 2'd0, "R1 mux", mux_sel, 0);

    // R7 unused bits and EOC write ignored, no start
    @(negedge clk);
    bus_write(CTRL, 8'h8E);
    bus_read(CTRL, v); chk(v == 8'h00, "R7 unused zero", v, 0);
    @(negedge clk);
    chk(dac_code == 8'h00, "R7 no conversion", dac_code, 0);

    // R10 other address
    bus_write(8'hF5, 8'h01);
    bus_read(CTRL, v); chk(v == 8'h00, "R10 ctrl untouched", v, 0);
    bus_read(8'hF5, v); chk(v == 8'h00, "R10 read zero", v, 0);
    @(negedge clk);
    chk(dac_code == 8'h00, "R10 no conversion", dac_code, 0);

    // R3 / R9 conversions with trial walk
    run_conv(2, 1'b1);
    run_conv(1, 1'b1);
    run_conv(3, 1'b1);
    ain[0] = 8'h00;
    run_conv(0, 1'b1);

    // R6 overwrite without intermediate read
    ain[3] = 8'hA5;
    exp_q.push_back(8'hA5);
    bus_write(CTRL, 8'h31);
    repeat (8*STEPS) @(negedge clk);
    publish();
    bus_read(DATA, v); chk(v == 8'hA5, "R6 overwrite", v, 8'hA5);

    // R7 EOC write ignored after completion
    bus_write(CTRL, 8'h00);
    bus_read(CTRL, v); chk(v == 8'h08, "R7 eoc kept", v, 8'h08);

    // R5 / R8 mid-conversion rewrite
    ain[2] = 8'h3C; ain[3] = 8'hC3;
    exp_q.push_back(8'h3C);
    bus_write(CTRL, 8'h21);
    t0 = cyc;
    repeat (3) @(negedge clk);
    bus_write(CTRL, 8'h31);
    chk(mux_sel == 2'd2, "R5 mux held", mux_sel, 2);
    bus_read(CTRL, v); chk(v == 8'h31, "R8 field updated busy", v, 8'h31);
    while (cyc < t0 + 8*STEPS - 1) @(negedge clk);
    bus_read(CTRL, v); chk(v == 8'h31, "R8 still busy", v, 8'h31);
    @(negedge clk);
    bus_read(CTRL, v); chk(v == 8'h38, "R8 done on time", v, 8'h38);
    publish();

    // R5 next conversion uses new channel
    run_conv(3, 1'b0);

    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule